// File: doc/BRIEF.md
# Paged External Memory Bus Sequencer

This block sits between an 8-bit processor core and its off-chip memory. The core hands it code fetches, data reads and data writes over a 16-bit address space. The block plays each request out as a bus cycle on two 8-bit pad ports. It uses an active-low address-latch strobe and three active-low access strobes: program store, read and write. When the cycle completes it returns a one-clock completion pulse to the core, together with the captured byte.

With page mode off, the block runs the classic multiplexed bus. In that bus the first port carries the low address byte and then the data, and the second port holds the high address byte. With page mode on, the block remembers the high address byte of the last external access. An access to the same high byte (a page hit) skips the address-latch phase. A 2-bit select chooses between two bus arrangements and sets the cycle length in clocks:

- **Split arrangement.** The second port carries the address, high byte then low byte, and the first port carries the data.
- **Muxed arrangement.** The first port carries the low address, and the second port carries the high byte and then the data.

Top module: `xmem_pager`

## Requirements
- R1: After reset, every strobe (`ale_n`, `psen_n`, `rd_n`, `wr_n`) is high, neither port is driven, `req_ready` is high and `done` is low.
- R2: With `cfg_page_en` low, every access takes 2 clocks with `ale_n` low, `pa_out` = low address byte and `pb_out` = high address byte, followed by 2 strobe clocks with `pb_out` = high byte. Data moves on the first port, and `cfg_sel` has no effect.
- R3: An access is a page hit only if the stored page is valid and its high address byte equals that of the previous external access. The stored page is invalid after reset and after any change of `cfg_page_en` or `cfg_sel`, so the next access is a miss.
- R4: With page mode on and `cfg_sel` = 00, 01 or 10, let H = 1, 2 or 4. A hit gives H strobe clocks with no address-latch clocks. A miss gives H address-latch clocks followed by H strobe clocks.
- R5: In the split arrangement, the second port drives the high byte while `ale_n` is low and the low byte during the strobe. The first port is not driven during the address-latch clocks.
- R6: `ale_n` is low only during the high-byte phase, and all of those clocks come before the strobe clocks. At most one strobe is low at a time, and all strobes are high in the clock that shows `done`.
- R7: A fetch (`req_kind` = 00) lowers only `psen_n` and leaves the data port undriven. The byte present on the data port in the last strobe clock is returned on `rdata`.
- R8: A read (`req_kind` = 01) lowers only `rd_n` with the data port undriven, and returns the data-port byte on `rdata`. A write (`req_kind` = 10 or 11) lowers only `wr_n` and drives `req_wdata` on the data port throughout the strobe.
- R9: With page mode on and `cfg_sel` = 11, `pa_out` carries the low address byte throughout the cycle. `pb_out` carries the high byte while `ale_n` is low, and `pb` is the data port during the strobe.
- R10: With `cfg_sel` = 11, a fetch hit takes 2 strobe clocks with no address-latch clocks, and a fetch miss takes 2 address-latch clocks plus 2 strobe clocks. Every read or write takes 2 address-latch clocks plus 2 strobe clocks, whether it hits or misses.
- R11: A request is taken when `req_valid` and `req_ready` are both high. `done` is high for exactly one clock after the last strobe clock, and `rdata` is valid in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_kind | input | 2 | 00 fetch, 01 read, 1x write |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Captured fetch/read byte |
| cfg_page_en | input | 1 | Page mode enable |
| cfg_sel | input | 2 | Speed / arrangement select |
| pa_out | output | 8 | First port output value |
| pa_oe | output | 1 | First port output enable |
| pa_in | input | 8 | First port pad input |
| pb_out | output | 8 | Second port output value |
| pb_oe | output | 1 | Second port output enable |
| pb_in | input | 8 | Second port pad input |
| ale_n | output | 1 | Address-latch strobe, active low |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The hardest case to reach from the ports is a page miss that is forced only by a configuration change. In that case the address is identical to the previous access, so only the invalidation of the stored page can make it a miss. The bench ends each configuration's address sequence on the same address that starts the next configuration, so an access that would otherwise hit must instead show the full address-latch phase. Within each configuration, the sequence alternates same-page and new-page addresses across all three access kinds. This also exercises the muxed-arrangement rule that data accesses never shorten.

// File: rtl/xmp_pkg.sv
package xmp_pkg;

  localparam int unsigned PH_W = 3;

  typedef enum logic [1:0] {
    BM_CLASSIC = 2'd0,
    BM_SPLIT   = 2'd1,
    BM_MUXED   = 2'd2
  } bus_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_XFER = 2'd2
  } seq_state_e;

  typedef struct packed {
    bus_mode_e         mode;
    logic [PH_W-1:0]   len;
    logic              skip_addr;
  } cyc_plan_t;

endpackage

// File: rtl/xmp_page_tracker.sv
module xmp_page_tracker #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_page_en,
  input  logic [1:0]        cfg_sel,
  input  logic              load,
  input  logic [BYTE_W-1:0] probe_hi,
  output logic              hit
);

  logic [2:0]        cfg_q, cfg_d;
  logic              valid_q, valid_d;
  logic [BYTE_W-1:0] page_q, page_d;
  logic              cfg_chg;

  assign cfg_chg = ({cfg_page_en, cfg_sel} != cfg_q);
  assign hit     = valid_q && !cfg_chg && (page_q == probe_hi);

  always_comb begin
    cfg_d   = {cfg_page_en, cfg_sel};
    valid_d = valid_q;
    page_d  = page_q;
    if (cfg_chg) valid_d = 1'b0;
    if (load) begin
      valid_d = 1'b1;
      page_d  = probe_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= 3'b000;
      valid_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) page_q <= page_d;
  end

endmodule

// File: rtl/xmp_cycle_plan.sv
module xmp_cycle_plan
  import xmp_pkg::*;
(
  input  logic       cfg_page_en,
  input  logic [1:0] cfg_sel,
  input  logic [1:0] kind,
  input  logic       hit,
  output cyc_plan_t  plan
);

  logic is_fetch;
  assign is_fetch = (kind == 2'b00);

  always_comb begin
    plan.mode      = BM_CLASSIC;
    plan.len       = PH_W'(2);
    plan.skip_addr = 1'b0;
    if (cfg_page_en) begin
      if (cfg_sel == 2'b11) begin
        plan.mode      = BM_MUXED;
        plan.len       = PH_W'(2);
        plan.skip_addr = hit && is_fetch;
      end else begin
        plan.mode      = BM_SPLIT;
        plan.len       = PH_W'(1) << cfg_sel;
        plan.skip_addr = hit;
      end
    end
  end

endmodule

// File: rtl/xmp_pin_drive.sv
module xmp_pin_drive
  import xmp_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned ADDR_W = 2 * BYTE_W
) (
  input  seq_state_e        state,
  input  bus_mode_e         mode,
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] pa_out,
  output logic              pa_oe,
  output logic [BYTE_W-1:0] pb_out,
  output logic              pb_oe,
  output logic              ale_n,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n
);

  logic [BYTE_W-1:0] lo_b, hi_b;
  logic              is_wr;

  assign lo_b  = addr[BYTE_W-1:0];
  assign hi_b  = addr[ADDR_W-1:BYTE_W];
  assign is_wr = kind[1];

  always_comb begin
    ale_n  = 1'b1;
    psen_n = 1'b1;
    rd_n   = 1'b1;
    wr_n   = 1'b1;
    pa_oe  = 1'b0;
    pb_oe  = 1'b0;
    pa_out = '0;
    pb_out = '0;
    unique case (state)
      ST_ADDR: begin
        ale_n  = 1'b0;
        pb_oe  = 1'b1;
        pb_out = hi_b;
        if (mode != BM_SPLIT) begin
          pa_oe  = 1'b1;
          pa_out = lo_b;
        end
      end
      ST_XFER: begin
        psen_n = !(kind == 2'b00);
        rd_n   = !(kind == 2'b01);
        wr_n   = !is_wr;
        unique case (mode)
          BM_MUXED: begin
            pa_oe  = 1'b1;
            pa_out = lo_b;
            pb_oe  = is_wr;
            pb_out = is_wr ? wdata : '0;
          end
          BM_SPLIT: begin
            pb_oe  = 1'b1;
            pb_out = lo_b;
            pa_oe  = is_wr;
            pa_out = is_wr ? wdata : '0;
          end
          default: begin
            pb_oe  = 1'b1;
            pb_out = hi_b;
            pa_oe  = is_wr;
            pa_out = is_wr ? wdata : '0;
          end
        endcase
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/xmem_pager.sv
module xmem_pager
  import xmp_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [BYTE_W-1:0] rdata,
  input  logic              cfg_page_en,
  input  logic [1:0]        cfg_sel,
  output logic [BYTE_W-1:0] pa_out,
  output logic              pa_oe,
  input  logic [BYTE_W-1:0] pa_in,
  output logic [BYTE_W-1:0] pb_out,
  output logic              pb_oe,
  input  logic [BYTE_W-1:0] pb_in,
  output logic              ale_n,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  seq_state_e        state_q, state_d;
  logic [PH_W-1:0]   cnt_q, cnt_d;
  logic              done_q, done_d;
  cyc_plan_t         plan_q, plan_new;
  logic [1:0]        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] wdata_q;
  logic [BYTE_W-1:0] rdata_q;
  logic              rdata_en;
  logic              accept;
  logic              page_hit;
  logic              phase_last;

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign phase_last = (cnt_q == PH_W'(plan_q.len - PH_W'(1)));

  xmp_page_tracker #(.BYTE_W(BYTE_W)) u_page (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .cfg_page_en (cfg_page_en),
    .cfg_sel     (cfg_sel),
    .load        (accept),
    .probe_hi    (req_addr[ADDR_W-1:BYTE_W]),
    .hit         (page_hit)
  );

  xmp_cycle_plan u_plan (
    .cfg_page_en (cfg_page_en),
    .cfg_sel     (cfg_sel),
    .kind        (req_kind),
    .hit         (page_hit),
    .plan        (plan_new)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    done_d   = 1'b0;
    rdata_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = plan_new.skip_addr ? ST_XFER : ST_ADDR;
          cnt_d   = '0;
        end
      end
      ST_ADDR: begin
        if (phase_last) begin
          state_d = ST_XFER;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + PH_W'(1);
        end
      end
      ST_XFER: begin
        if (phase_last) begin
          state_d  = ST_IDLE;
          cnt_d    = '0;
          done_d   = 1'b1;
          rdata_en = !kind_q[1];
        end else begin
          cnt_d = cnt_q + PH_W'(1);
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk) begin
    if (accept) begin
      plan_q  <= plan_new;
      kind_q  <= req_kind;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // returned byte, enabled on the last strobe clock
  always_ff @(posedge clk) begin
    if (rdata_en) begin
      rdata_q <= (plan_q.mode == BM_MUXED) ? pb_in : pa_in;
    end
  end

  assign done  = done_q;
  assign rdata = rdata_q;

  xmp_pin_drive #(.BYTE_W(BYTE_W)) u_pins (
    .state  (state_q),
    .mode   (plan_q.mode),
    .kind   (kind_q),
    .addr   (addr_q),
    .wdata  (wdata_q),
    .pa_out (pa_out),
    .pa_oe  (pa_oe),
    .pb_out (pb_out),
    .pb_oe  (pb_oe),
    .ale_n  (ale_n),
    .psen_n (psen_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n)
  );

endmodule

// File: rtl/xmem_pager_chk.sv
module xmem_pager_chk (
  input logic clk,
  input logic rst_n,
  input logic ale_n,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic pa_oe,
  input logic pb_oe,
  input logic done,
  input logic req_ready
);

  logic any_strobe;
  assign any_strobe = !psen_n || !rd_n || !wr_n;

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!ale_n, !psen_n, !rd_n, !wr_n}));

  assert_quiet_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ale_n && !any_strobe));

  assert_latch_then_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_n |=> (!ale_n || any_strobe));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ale_n && !any_strobe));

  assert_latch_drives_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_n |-> pb_oe);

  assert_fetch_one_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> ($countones({pa_oe, pb_oe}) == 1));

  assert_read_one_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> ($countones({pa_oe, pb_oe}) == 1));

  assert_write_both_ports_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (pa_oe && pb_oe));

endmodule

bind xmem_pager xmem_pager_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ale_n     (ale_n),
  .psen_n    (psen_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .pa_oe     (pa_oe),
  .pb_oe     (pb_oe),
  .done      (done),
  .req_ready (req_ready)
);

// File: tb/xmem_pager_tb.sv
module xmem_pager_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready;
  logic        done;
  logic [7:0]  rdata;
  logic        cfg_page_en;
  logic [1:0]  cfg_sel;
  logic [7:0]  pa_out, pb_out, pa_in, pb_in;
  logic        pa_oe, pb_oe;
  logic        ale_n, psen_n, rd_n, wr_n;

  int tests;
  int fails;
  bit finished;

  logic [15:0] cur_addr;
  bit          muxed_cfg;
  bit          pg_valid;
  logic [7:0]  pg_hi;

  function automatic logic [7:0] mval(input logic [15:0] a);
    mval = (a[15:8] * 8'd3) ^ a[7:0] ^ 8'hA5;
  endfunction

  assign pa_in = muxed_cfg ? ~mval(cur_addr) : mval(cur_addr);
  assign pb_in = muxed_cfg ? mval(cur_addr) : ~mval(cur_addr);

  xmem_pager u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rdata(rdata), .cfg_page_en(cfg_page_en), .cfg_sel(cfg_sel),
    .pa_out(pa_out), .pa_oe(pa_oe), .pa_in(pa_in), .pb_out(pb_out),
    .pb_oe(pb_oe), .pb_in(pb_in), .ale_n(ale_n), .psen_n(psen_n),
    .rd_n(rd_n), .wr_n(wr_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic set_cfg(input bit en, input logic [1:0] sel);
    cfg_page_en = en;
    cfg_sel     = sel;
    muxed_cfg   = en && (sel == 2'b11);
    pg_valid    = 0;
    @(negedge clk);
  endtask

  task automatic run(input logic [1:0] kind, input logic [15:0] addr,
                     input logic [7:0] wd, input bit first_in_cfg);
    bit   hit;
    int   ea, ex, na, nx, guard, bad_ports, bad_strobe, bad_order;
    bit   seen_x;
    bit   is_wr;
    string len_tag, port_tag, kind_tag;
    logic [7:0] lo, hi;
    lo    = addr[7:0];
    hi    = addr[15:8];
    is_wr = kind[1];
    hit   = pg_valid && (pg_hi == hi);
    if (!cfg_page_en) begin
      ea = 2; ex = 2; len_tag = "R2"; port_tag = "R2";
    end else if (cfg_sel == 2'b11) begin
      ex = 2; ea = (kind == 2'b00 && hit) ? 0 : 2;
      len_tag = "R10"; port_tag = "R9";
    end else begin
      ex = 1 << cfg_sel; ea = hit ? 0 : ex;
      len_tag = "R4"; port_tag = "R5";
    end
    kind_tag = (kind == 2'b00) ? "R7" : "R8";
    cur_addr  = addr;
    req_kind  = kind;
    req_addr  = addr;
    req_wdata = wd;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    na = 0; nx = 0; guard = 0; bad_ports = 0; bad_strobe = 0; bad_order = 0;
    seen_x = 0;
    while (!done && guard < 40) begin
      if (!ale_n) begin
        na++;
        if (seen_x) bad_order++;
        if (!pb_oe || pb_out != hi) bad_ports++;
        if (muxed_cfg || !cfg_page_en) begin
          if (!pa_oe || pa_out != lo) bad_ports++;
        end else if (pa_oe) bad_ports++;
      end
      if (!psen_n || !rd_n || !wr_n) begin
        nx++;
        seen_x = 1;
        if (psen_n != (kind != 2'b00) || rd_n != (kind != 2'b01) || wr_n != !is_wr)
          bad_strobe++;
        if (muxed_cfg) begin
          if (!pa_oe || pa_out != lo) bad_ports++;
          if (is_wr ? (!pb_oe || pb_out != wd) : pb_oe) bad_ports++;
        end else begin
          if (!pb_oe || pb_out != (cfg_page_en ? lo : hi)) bad_ports++;
          if (is_wr ? (!pa_oe || pa_out != wd) : pa_oe) bad_ports++;
        end
      end
      @(negedge clk);
      guard++;
    end
    if (first_in_cfg && cfg_page_en)
      chk(na == ea, "R3", "miss after config change, latch clocks", na, ea);
    chk(na == ea, len_tag, "address-latch clocks", na, ea);
    chk(nx == ex, len_tag, "strobe clocks", nx, ex);
    chk(bad_ports == 0, port_tag, "port drive mismatches", bad_ports, 0);
    chk(bad_strobe == 0, kind_tag, "wrong strobe clocks", bad_strobe, 0);
    chk(bad_order == 0, "R6", "latch clocks after strobe", bad_order, 0);
    chk(done == 1'b1, "R11", "done seen", int'(done), 1);
    chk(ale_n && psen_n && rd_n && wr_n, "R6", "strobes idle at done", 0, 0);
    if (!is_wr)
      chk(rdata == mval(addr), kind_tag, "returned byte", rdata, mval(addr));
    @(negedge clk);
    chk(done == 1'b0, "R11", "done single clock", int'(done), 0);
    pg_valid = 1;
    pg_hi    = hi;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 1 expected 0");
    finish_run();
  end

  initial begin
    logic [15:0] seq [6];
    bit          cen [6];
    logic [1:0]  csel [6];
    tests = 0; fails = 0; finished = 0;
    req_valid = 0; req_kind = 0; req_addr = 0; req_wdata = 0;
    cfg_page_en = 0; cfg_sel = 0; muxed_cfg = 0; pg_valid = 0; pg_hi = 0;
    cur_addr = 0;
    seq[0] = 16'h1234; seq[1] = 16'h1256; seq[2] = 16'h3456;
    seq[3] = 16'h3400; seq[4] = 16'h12FF; seq[5] = 16'h1234;
    cen[0] = 0; csel[0] = 2'b00;
    cen[1] = 1; csel[1] = 2'b00;
    cen[2] = 1; csel[2] = 2'b01;
    cen[3] = 1; csel[3] = 2'b10;
    cen[4] = 1; csel[4] = 2'b11;
    cen[5] = 0; csel[5] = 2'b11;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    chk(ale_n && psen_n && rd_n && wr_n, "R1", "strobes high after reset",
        int'({ale_n, psen_n, rd_n, wr_n}), 15);
    chk(!pa_oe && !pb_oe, "R1", "ports undriven after reset",
        int'({pa_oe, pb_oe}), 0);
    for (int c = 0; c < 6; c++) begin
      set_cfg(cen[c], csel[c]);
      for (int k = 0; k < 3; k++) begin
        for (int a = 0; a < 6; a++) begin
          logic [1:0] kd;
          kd = (k == 2) ? 2'b10 : 2'(k);
          run(kd, seq[a], 8'(8'h3C + a * 17 + c), (k == 0 && a == 0));
        end
      end
    end
    finish_run();
  end

endmodule